// File: doc/BRIEF.md
# Four-Channel Fixed-Priority DMA Engine

This block moves single bytes between memory and peripherals on behalf of up to four requesting devices. It sits on an 8-bit data, 16-bit address bus. While it does not own the bus, software programs it through a small register window. Each channel has a 16-bit start address and a 16-bit count word. The count word carries the transfer count minus one and the cycle type. A shared enable register and a sticky status register complete the window.

When an enabled channel raises its request, the engine asks the processor for the bus. It waits for the hold acknowledge and then grants the lowest-numbered pending channel. It runs one byte transfer in two cycles. In the first cycle, the upper address byte is presented on the data pins with a latch strobe. In the second cycle, the engine drives the acknowledge and the memory and I/O strobes. After each byte the engine releases the bus, so that arbitration happens again before every transfer. The terminal-count output marks the final byte of a channel's block.

Top module: `dma4_engine`

## Requirements
- R1: When several enabled channels request at the moment the bus is granted, the channel with the lowest index is served first.
- R2: Loading N-1 into count bits [13:0] yields exactly N transfers for that channel. The `tc` output is high in the transfer cycle of the last of them and in no other cycle.
- R3: A channel's terminal-count flag (status bit = channel index) sets after its last transfer. It stays set until a status read, and that read returns the flag and clears it.
- R4: `hold_req` rises when an enabled channel has its request high. No address strobe or transfer happens until `hold_ack` is high. `hold_req` falls after each single-byte transfer.
- R5: `dack_n[i]` is low only in the transfer cycle of a byte for channel i, and at most one acknowledge is low at a time.
- R6: Count bits [15:14] select the cycle type. With 10 (read), `mem_rd_n` and `io_wr_n` go low. With 01 (write), `io_rd_n` and `mem_wr_n` go low. With 00 or 11 (verify), only the acknowledge is driven and all four strobes stay high.
- R7: The cycle before each transfer has `adstb` high and `data_oe` high, with `data_out` holding address bits [15:8]. `addr_lo` carries address bits [3:0] in that cycle and in the transfer cycle.
- R8: After each transfer, the channel address increments by one with 16-bit wrap and the count decrements. At terminal count the channel's enable clears, so further requests are ignored.
- R9: Register access requires `cs_n` low and the engine idle (`hold_req` low). At `reg_addr` 0..7, bits [2:1] select the channel and bit 0 selects the address (0) or the count (1). At address 8, a write sets the enables from `data_in[3:0]` and a read returns the status.
- R10: 16-bit registers are written low byte then high byte through an internal byte toggle. The toggle is cleared by reset and by any write to address 8.
- R11: After reset the engine is idle: `hold_req`, `adstb`, `tc` and `data_oe` are low, all `dack_n` bits and strobes are high, and the status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Register window select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| reg_addr | input | 4 | Register index |
| data_in | input | 8 | Data bus input |
| data_out | output | 8 | Data bus output (status or upper address byte) |
| data_oe | output | 1 | Data bus output enable |
| dreq | input | 4 | Channel requests, active high |
| hold_ack | input | 1 | Processor has released the bus |
| hold_req | output | 1 | Bus request to the processor |
| dack_n | output | 4 | Channel acknowledges, active low |
| addr_lo | output | 4 | Address bits [3:0] |
| adstb | output | 1 | Upper address byte latch strobe |
| aen | output | 1 | Engine drives the address and control lines |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Terminal count, high on the last transfer |

## Verification
The assertions assume that the processor keeps `hold_ack` high from the moment it grants the bus until `hold_req` drops. The bench's acknowledge responder follows `hold_req` with one cycle of delay and never withdraws early. The assertions also assume that software touches the register window only while the engine is idle. The bench programs channels before raising requests, and it lowers a channel's request only between transfers. Register strobes are held for exactly one clock per access, because every clock with the strobe low counts as one access.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_ADDR = 2'd2,
        S_XFER = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        CY_VERIFY = 2'b00,
        CY_WRITE  = 2'b01,
        CY_READ   = 2'b10,
        CY_RSVD   = 2'b11
    } cyc_t;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobe_t;

    function automatic strobe_t cyc_strobes(input cyc_t c, input logic act);
        strobe_t s;
        s = '1;
        if (act) begin
            case (c)
                CY_READ:  begin s.mem_rd_n = 1'b0; s.io_wr_n = 1'b0; end
                CY_WRITE: begin s.io_rd_n = 1'b0; s.mem_wr_n = 1'b0; end
                default:  ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW,
    localparam int CW = 2 * DW - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic          stat_rd,
    input  logic          step,
    output logic [AW-1:0] addr,
    output cyc_t          ctype,
    output logic          en,
    output logic          tc_flag,
    output logic          at_last
);

    logic [CW-1:0] cnt;

    assign at_last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            cnt     <= '0;
            ctype   <= CY_VERIFY;
            en      <= 1'b0;
            tc_flag <= 1'b0;
        end else begin
            if (wr_addr) begin
                if (wr_hi) addr[AW-1:DW] <= wdata;
                else       addr[DW-1:0]  <= wdata;
            end
            if (wr_cnt) begin
                if (wr_hi) begin
                    ctype        <= cyc_t'(wdata[DW-1:DW-2]);
                    cnt[CW-1:DW] <= wdata[DW-3:0];
                end else begin
                    cnt[DW-1:0]  <= wdata;
                end
            end
            if (en_wr)   en      <= en_val;
            if (stat_rd) tc_flag <= 1'b0;
            if (step) begin
                addr <= addr + 1'b1;
                cnt  <= cnt - 1'b1;
                if (at_last) begin
                    en      <= 1'b0;
                    tc_flag <= 1'b1;
                end
            end
        end
    end

    // R8
    en_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (step && at_last) |=> !en);

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_flag && !stat_rd) |=> tc_flag);

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    // R1
    always_comb begin
        grant_onehot_chk: assert ($onehot0(grant));
        grant_match_chk: assert (!any || grant[idx]);
    end

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
    import dma4_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_pend,
    input  logic [IW-1:0] pick,
    input  logic          hold_ack,
    input  logic          at_last,
    input  cyc_t          ctype,
    output logic [IW-1:0] cur,
    output logic          hold_req,
    output logic          adstb,
    output logic          xfer,
    output logic          tc,
    output strobe_t       str
);

    seq_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                S_IDLE: if (any_pend) state <= S_REQ;
                S_REQ: begin
                    if (hold_ack) begin
                        if (any_pend) begin
                            state <= S_ADDR;
                            cur   <= pick;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                end
                S_ADDR:  state <= S_XFER;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign hold_req = (state != S_IDLE);
    assign adstb    = (state == S_ADDR);
    assign xfer     = (state == S_XFER);
    assign tc       = xfer && at_last;
    assign str      = cyc_strobes(ctype, xfer);

    // R4
    ack_before_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(adstb) |-> $past(hold_ack));

    // R7
    addr_then_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        adstb |=> (xfer && $stable(cur)));

    // R6
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!str.mem_rd_n && !str.mem_wr_n) && !(!str.io_rd_n && !str.io_wr_n));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (rst)
        xfer |=> !hold_req);

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW = 8,
    localparam int CHW = $clog2(NUM_CH),
    localparam int RA_W = CHW + 2,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DW-1:0]     data_in,
    output logic [DW-1:0]     data_out,
    output logic              data_oe,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              hold_ack,
    output logic              hold_req,
    output logic [NUM_CH-1:0] dack_n,
    output logic [3:0]        addr_lo,
    output logic              adstb,
    output logic              aen,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              tc
);

    logic              acc, reg_wr, reg_rd, is_mode, is_cnt, stat_rd, ff_hi;
    logic [CHW-1:0]    ch_sel, cur, pick;
    logic [NUM_CH-1:0] ch_en, ch_tc, ch_last, pend, grant;
    logic [AW-1:0]     ch_addr [NUM_CH];
    cyc_t              ch_type [NUM_CH];
    logic              any_pend, xfer, step;
    strobe_t           str;

    assign acc     = !cs_n && !hold_req;
    assign reg_wr  = acc && !wr_n;
    assign reg_rd  = acc && !rd_n;
    assign is_mode = reg_addr[RA_W-1];
    assign ch_sel  = reg_addr[RA_W-2:1];
    assign is_cnt  = reg_addr[0];
    assign stat_rd = reg_rd && is_mode;

    always_ff @(posedge clk) begin
        if (rst)                    ff_hi <= 1'b0;
        else if (reg_wr && is_mode) ff_hi <= 1'b0;
        else if (reg_wr)            ff_hi <= ~ff_hi;
    end

    assign pend = dreq & ch_en;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel_i;
        assign sel_i = reg_wr && !is_mode && (ch_sel == CHW'(i));
        dma4_chan #(.DW(DW)) i_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_addr (sel_i && !is_cnt),
            .wr_cnt  (sel_i && is_cnt),
            .wr_hi   (ff_hi),
            .wdata   (data_in),
            .en_wr   (reg_wr && is_mode),
            .en_val  (data_in[i]),
            .stat_rd (stat_rd),
            .step    (step && (cur == CHW'(i))),
            .addr    (ch_addr[i]),
            .ctype   (ch_type[i]),
            .en      (ch_en[i]),
            .tc_flag (ch_tc[i]),
            .at_last (ch_last[i])
        );
        assign dack_n[i] = !(xfer && (cur == CHW'(i)));
    end

    dma4_arb #(.N(NUM_CH)) i_arb (
        .req   (pend),
        .grant (grant),
        .idx   (pick),
        .any   (any_pend)
    );

    dma4_seq #(.IW(CHW)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .any_pend (any_pend),
        .pick     (pick),
        .hold_ack (hold_ack),
        .at_last  (ch_last[cur]),
        .ctype    (ch_type[cur]),
        .cur      (cur),
        .hold_req (hold_req),
        .adstb    (adstb),
        .xfer     (xfer),
        .tc       (tc),
        .str      (str)
    );

    assign step     = xfer;
    assign aen      = adstb || xfer;
    assign addr_lo  = ch_addr[cur][3:0];
    assign mem_rd_n = str.mem_rd_n;
    assign mem_wr_n = str.mem_wr_n;
    assign io_rd_n  = str.io_rd_n;
    assign io_wr_n  = str.io_wr_n;
    assign data_oe  = adstb || stat_rd;

    always_comb begin
        data_out = '0;
        if (adstb)        data_out = ch_addr[cur][AW-1:DW];
        else if (stat_rd) data_out[NUM_CH-1:0] = ch_tc;
    end

    // R5
    dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    // R2
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> !(&dack_n));

    // R9
    no_access_busy_chk: assert property (@(posedge clk) disable iff (rst)
        aen |-> !stat_rd);

endmodule

// File: tb/test_dma4_engine.sv
module test_dma4_engine;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] reg_addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;
    logic [3:0] dreq = '0;
    logic       hold_ack = 1'b0;
    logic       hold_req;
    logic [3:0] dack_n;
    logic [3:0] addr_lo;
    logic       adstb, aen, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc;
    logic       ack_en = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) hold_ack <= ack_en && hold_req;

    dma4_engine i_dma4_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_addr(reg_addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hold_req), .dack_n(dack_n), .addr_lo(addr_lo),
        .adstb(adstb), .aen(aen), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc)
    );

    // {channel, start address, count N-1, cycle type}
    localparam logic [33:0] VEC [4] = '{
        {2'd0, 16'h12FE, 14'd2, 2'b10},
        {2'd1, 16'h4000, 14'd0, 2'b01},
        {2'd2, 16'h00A5, 14'd1, 2'b00},
        {2'd3, 16'hFFFF, 14'd1, 2'b10}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d, input bit sel = 1);
        @(negedge clk);
        cs_n = !sel; wr_n = 1'b0; reg_addr = a; data_in = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic stat_rd(output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; reg_addr = 4'h8;
        #1 v = data_out;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic program_ch(input logic [1:0] ch, input logic [15:0] a,
                              input logic [13:0] c, input logic [1:0] ty);
        reg_wr({1'b0, ch, 1'b0}, a[7:0]);
        reg_wr({1'b0, ch, 1'b0}, a[15:8]);
        reg_wr({1'b0, ch, 1'b1}, c[7:0]);
        reg_wr({1'b0, ch, 1'b1}, {ty, c[13:8]});
    endtask

    task automatic wait_adstb(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk);
            if (adstb) seen = 1'b1;
        end
    endtask

    function automatic logic [3:0] exp_str(input logic [1:0] ty);
        case (ty)
            2'b10:   return 4'b0110;
            2'b01:   return 4'b1001;
            default: return 4'b1111;
        endcase
    endfunction

    // one byte transfer: address cycle then transfer cycle
    task automatic one_xfer(input logic [1:0] ch, input logic [15:0] a,
                            input logic [1:0] ty, input bit last);
        bit seen;
        wait_adstb(seen);
        check(seen, "R4 address cycle reached", 32'(seen), 1);
        check(data_oe && data_out == a[15:8], "R7 upper address byte",
              {data_oe, data_out}, {1'b1, a[15:8]});
        check(addr_lo == a[3:0], "R7 low address in strobe cycle", addr_lo, a[3:0]);
        @(negedge clk);
        check(dack_n == ~(4'b1 << ch), "R5 acknowledge", dack_n, ~(4'b1 << ch));
        check({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == exp_str(ty), "R6 strobes",
              {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, exp_str(ty));
        check(tc == last, "R2 terminal count", tc, last);
        check(addr_lo == a[3:0], "R7 low address in transfer", addr_lo, a[3:0]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        bit seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!hold_req && !adstb && !tc && !data_oe, "R11 idle outputs",
              {hold_req, adstb, tc, data_oe}, 0);
        check(dack_n == 4'hF && {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF,
              "R11 acknowledges and strobes high",
              {dack_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 8'hFF);
        stat_rd(v);
        check(v == 8'h00, "R11 status zero", v, 0);

        // vector table: R2 R3 R6 R7 R8
        foreach (VEC[i]) begin
            logic [1:0]  ch;
            logic [15:0] a;
            logic [13:0] c;
            logic [1:0]  ty;
            {ch, a, c, ty} = VEC[i];
            reg_wr(4'h8, 8'h00);
            program_ch(ch, a, c, ty);
            reg_wr(4'h8, 8'(4'b1 << ch));
            dreq[ch] = 1'b1;
            for (int k = 0; k <= int'(c); k++) begin
                one_xfer(ch, a, ty, k == int'(c));
                a = a + 16'd1;
            end
            dreq[ch] = 1'b0;
            repeat (3) @(negedge clk);
            stat_rd(v);
            check(v == 8'(4'b1 << ch), "R3 flag after last transfer", v, 8'(4'b1 << ch));
            stat_rd(v);
            check(v == 8'h00, "R3 flag cleared by read", v, 0);
            dreq[ch] = 1'b1;
            repeat (6) @(negedge clk);
            check(!hold_req, "R8 enable cleared at terminal count", hold_req, 0);
            dreq[ch] = 1'b0;
        end

        // R9 write with chip select high is ignored
        reg_wr(4'h8, 8'h00);
        program_ch(2'd0, 16'h2233, 14'd0, 2'b01);
        reg_wr(4'h8, 8'h01, 1'b0);
        dreq[0] = 1'b1;
        repeat (6) @(negedge clk);
        check(!hold_req, "R9 no enable without chip select", hold_req, 0);
        reg_wr(4'h8, 8'h01);
        one_xfer(2'd0, 16'h2233, 2'b01, 1'b1);
        dreq[0] = 1'b0;
        stat_rd(v);

        // R10 byte toggle cleared by a mode write
        reg_wr(4'h2, 8'h77);
        reg_wr(4'h8, 8'h00);
        reg_wr(4'h2, 8'h34);
        reg_wr(4'h2, 8'h56);
        reg_wr(4'h3, 8'h00);
        reg_wr(4'h3, 8'h80);
        reg_wr(4'h8, 8'h02);
        dreq[1] = 1'b1;
        one_xfer(2'd1, 16'h5634, 2'b10, 1'b1); // R10 byte order
        dreq[1] = 1'b0;
        stat_rd(v);

        // R4 no transfer before hold acknowledge
        ack_en = 1'b0;
        reg_wr(4'h8, 8'h00);
        program_ch(2'd3, 16'h0108, 14'd0, 2'b01);
        reg_wr(4'h8, 8'h08);
        dreq[3] = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (adstb || dack_n != 4'hF) seen = 1'b1;
        end
        check(hold_req && !seen, "R4 waits for hold acknowledge", {hold_req, seen}, 2'b10);
        ack_en = 1'b1;
        one_xfer(2'd3, 16'h0108, 2'b01, 1'b1);
        dreq[3] = 1'b0;
        @(negedge clk);
        check(!hold_req, "R4 bus released after transfer", hold_req, 0);
        stat_rd(v);

        // R1 fixed priority: channels 1 and 2 both pending, then 0 against 3
        reg_wr(4'h8, 8'h00);
        program_ch(2'd1, 16'h3000, 14'd0, 2'b10);
        program_ch(2'd2, 16'h3100, 14'd0, 2'b01);
        reg_wr(4'h8, 8'h06);
        dreq = 4'b0110;
        one_xfer(2'd1, 16'h3000, 2'b10, 1'b1); // R1 lower index first
        one_xfer(2'd2, 16'h3100, 2'b01, 1'b1);
        dreq = 4'b0000;
        stat_rd(v);
        check(v == 8'h06, "R3 both flags", v, 8'h06);

        reg_wr(4'h8, 8'h00);
        program_ch(2'd0, 16'h4400, 14'd0, 2'b00);
        program_ch(2'd3, 16'h4500, 14'd0, 2'b00);
        reg_wr(4'h8, 8'h09);
        dreq = 4'b1001;
        one_xfer(2'd0, 16'h4400, 2'b00, 1'b1); // R1 channel 0 over 3
        one_xfer(2'd3, 16'h4500, 2'b00, 1'b1);
        dreq = 4'b0000;

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule